// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Controller

This block sits in front of the execute stage of an in-order five-stage pipeline and supplies the two ALU operands. For each operand it compares the source register number held in the decode/execute latch against the destination numbers of the two instructions ahead of it. Those two instructions sit in the execute/memory latch and the memory/writeback latch. When one of them is about to write the needed register, its result is steered into the operand mux in place of the register-file read. If both of them write that register, the younger one wins.

No path is needed from the stage beyond writeback. The register file is written in the first half of the cycle and read in the second half, so a value being retired is already visible to decode.

A load's data does not exist until the memory stage ends, so the instruction directly behind a load cannot take that value from the execute/memory latch. The parameter `DELAY_SLOT` selects how this load-use case is handled:
- With `DELAY_SLOT = 0`, the block raises a stall request so the surrounding pipeline can hold the consumer for one cycle.
- With `DELAY_SLOT = 1`, the slot after a load is a delayed-load slot. The consumer receives the older register value and no stall is raised.

The operand selection logic is combinational. The clock and reset inputs only time the embedded checks.

Top module: `fwd_ctl`

## Requirements
- R1: When neither older instruction writes the source register, the select code is 2'b00 and the operand equals the register-file read data.
- R2: When the execute/memory instruction is a non-load with its write enable set and its destination equals the source, the select is 2'b01 and the operand equals the execute/memory result.
- R3: When only the memory/writeback instruction writes the source register, the select is 2'b10 and the operand equals the memory/writeback data.
- R4: When both older instructions write the source register, the younger (execute/memory) value is chosen, with select 2'b01.
- R5: Register 0 is never forwarded, and a load with destination 0 never causes a stall.
- R6: A producer whose write enable is low is never forwarded and never causes a stall.
- R7: A load in the execute/memory latch is never forwarded. The operand falls back to the memory/writeback data if that instruction matches (2'b10), otherwise to the register file (2'b00).
- R8: With DELAY_SLOT = 0, the stall request is high exactly when a write-enabled load in the execute/memory latch, with a nonzero destination, matches either source register.
- R9: With DELAY_SLOT = 1, the stall request stays low for every input.
- R10: Operands A and B are selected independently, and each may take a different source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the embedded checks |
| rst | input | 1 | Synchronous active-high reset for the checks |
| src_a_idx | input | IDX_W | Source register number of operand A (decode/execute latch) |
| src_b_idx | input | IDX_W | Source register number of operand B (decode/execute latch) |
| rf_a_data | input | DATA_W | Register-file read value for operand A |
| rf_b_data | input | DATA_W | Register-file read value for operand B |
| xm_dst | input | IDX_W | Destination register in the execute/memory latch |
| xm_wen | input | 1 | Register write enable in the execute/memory latch |
| xm_is_load | input | 1 | Execute/memory instruction is a load |
| xm_result | input | DATA_W | ALU result held in the execute/memory latch |
| mw_dst | input | IDX_W | Destination register in the memory/writeback latch |
| mw_wen | input | 1 | Register write enable in the memory/writeback latch |
| mw_data | input | DATA_W | Result or load data in the memory/writeback latch |
| opnd_a | output | DATA_W | Selected operand A |
| opnd_b | output | DATA_W | Selected operand B |
| sel_a | output | 2 | Operand A source: 00 register file, 01 execute/memory, 10 memory/writeback |
| sel_b | output | 2 | Operand B source, same encoding |
| stall_req | output | 1 | Load-use stall request |

## Verification
Each source is exercised alone, so that the three select codes can be told apart: no producer, an execute/memory producer only, and a memory/writeback producer only. Both producers matching the same register separates youngest-first priority from oldest-first. Register 0 and disabled write enables check that the match also depends on the destination's value and on the enable, not only on index equality. Loads in the execute/memory latch are applied to two instances, one built for stalling and one built with a delayed slot. Comparing them shows that the fallback choice is shared by both modes and that only the stall differs.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF = 2'b00,
        SEL_XM = 2'b01,
        SEL_MW = 2'b10
    } fwd_sel_e;

    localparam int N_OPND = 2;

    // Youngest valid producer wins; register file is the fallback.
    function automatic fwd_sel_e pick_source(input logic xm_ok, input logic mw_ok);
        if (xm_ok)      return SEL_XM;
        else if (mw_ok) return SEL_MW;
        else            return SEL_RF;
    endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src,
    input  logic [IDX_W-1:0] xm_dst,
    input  logic             xm_wen,
    input  logic             xm_is_load,
    input  logic [IDX_W-1:0] mw_dst,
    input  logic             mw_wen,
    output fwd_sel_e         sel,
    output logic             load_use
);
    logic xm_hit;
    logic mw_hit;

    always_comb begin
        xm_hit   = xm_wen && (xm_dst != '0) && (xm_dst == src);
        mw_hit   = mw_wen && (mw_dst != '0) && (mw_dst == src);
        load_use = xm_hit && xm_is_load;
        sel      = pick_source(xm_hit && !xm_is_load, mw_hit);
    end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_data,
    input  logic [DATA_W-1:0] xm_data,
    input  logic [DATA_W-1:0] mw_data,
    output logic [DATA_W-1:0] value
);
    always_comb begin
        unique case (sel)
            SEL_XM:  value = xm_data;
            SEL_MW:  value = mw_data;
            default: value = rf_data;
        endcase
    end
endmodule

// File: rtl/fwd_ctl.sv
module fwd_ctl
    import fwd_pkg::*;
#(
    parameter int IDX_W      = 5,
    parameter int DATA_W     = 32,
    parameter bit DELAY_SLOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic [DATA_W-1:0] rf_a_data,
    input  logic [DATA_W-1:0] rf_b_data,
    input  logic [IDX_W-1:0]  xm_dst,
    input  logic              xm_wen,
    input  logic              xm_is_load,
    input  logic [DATA_W-1:0] xm_result,
    input  logic [IDX_W-1:0]  mw_dst,
    input  logic              mw_wen,
    input  logic [DATA_W-1:0] mw_data,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic              stall_req
);
    logic [IDX_W-1:0]  src_v  [N_OPND];
    logic [DATA_W-1:0] rf_v   [N_OPND];
    logic [DATA_W-1:0] val_v  [N_OPND];
    fwd_sel_e          sel_v  [N_OPND];
    logic [N_OPND-1:0] lu_v;

    assign src_v[0] = src_a_idx;
    assign src_v[1] = src_b_idx;
    assign rf_v[0]  = rf_a_data;
    assign rf_v[1]  = rf_b_data;

    for (genvar g = 0; g < N_OPND; g++) begin : g_lane
        fwd_match #(.IDX_W(IDX_W)) u_match (
            .src(src_v[g]), .xm_dst(xm_dst), .xm_wen(xm_wen),
            .xm_is_load(xm_is_load), .mw_dst(mw_dst), .mw_wen(mw_wen),
            .sel(sel_v[g]), .load_use(lu_v[g])
        );
        fwd_mux #(.DATA_W(DATA_W)) u_mux (
            .sel(sel_v[g]), .rf_data(rf_v[g]), .xm_data(xm_result),
            .mw_data(mw_data), .value(val_v[g])
        );
    end

    assign opnd_a = val_v[0];
    assign opnd_b = val_v[1];
    assign sel_a  = sel_v[0];
    assign sel_b  = sel_v[1];

    if (DELAY_SLOT) begin : g_delay
        assign stall_req = 1'b0;
        // R9: delayed-load slot never requests a stall
        p_no_stall_r9: assert property (@(posedge clk) disable iff (rst)
            !stall_req);
    end else begin : g_stall
        assign stall_req = |lu_v;
    end

    // R1: unused code never appears on a select
    p_sel_legal_r1: assert property (@(posedge clk) disable iff (rst)
        (sel_a != 2'b11) && (sel_b != 2'b11));
    // R2: execute/memory select delivers its result
    p_xm_value_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_a == 2'b01) |-> (opnd_a == xm_result));
    // R3: memory/writeback select delivers its data
    p_mw_value_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_b == 2'b10) |-> (opnd_b == mw_data));
    // R5: register 0 is read from the register file
    p_zero_reg_r5: assert property (@(posedge clk) disable iff (rst)
        (src_a_idx == '0) |-> (sel_a == 2'b00 && opnd_a == rf_a_data));
    // R7: a load result is never bypassed from execute/memory
    p_no_load_fwd_r7: assert property (@(posedge clk) disable iff (rst)
        xm_is_load |-> (sel_a != 2'b01 && sel_b != 2'b01));
    // R8: a stall only arises from an enabled load
    p_stall_src_r8: assert property (@(posedge clk) disable iff (rst)
        stall_req |-> (xm_is_load && xm_wen && xm_dst != '0));
endmodule

// File: tb/fwd_ctl_tb.sv
module fwd_ctl_tb;
    localparam int IW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic [IW-1:0] sa, sb, xd, md;
    logic          xw, xl, mw;
    logic [DW-1:0] rfa, rfb, xr, mwd;
    logic [DW-1:0] oa, ob, oa_d, ob_d;
    logic [1:0]    sela, selb, sela_d, selb_d;
    logic          stl, stl_d;

    fwd_ctl #(.IDX_W(IW), .DATA_W(DW), .DELAY_SLOT(1'b0)) u_dut (
        .clk(clk), .rst(rst), .src_a_idx(sa), .src_b_idx(sb),
        .rf_a_data(rfa), .rf_b_data(rfb), .xm_dst(xd), .xm_wen(xw),
        .xm_is_load(xl), .xm_result(xr), .mw_dst(md), .mw_wen(mw),
        .mw_data(mwd), .opnd_a(oa), .opnd_b(ob), .sel_a(sela),
        .sel_b(selb), .stall_req(stl));

    fwd_ctl #(.IDX_W(IW), .DATA_W(DW), .DELAY_SLOT(1'b1)) u_dut_dly (
        .clk(clk), .rst(rst), .src_a_idx(sa), .src_b_idx(sb),
        .rf_a_data(rfa), .rf_b_data(rfb), .xm_dst(xd), .xm_wen(xw),
        .xm_is_load(xl), .xm_result(xr), .mw_dst(md), .mw_wen(mw),
        .mw_data(mwd), .opnd_a(oa_d), .opnd_b(ob_d), .sel_a(sela_d),
        .sel_b(selb_d), .stall_req(stl_d));

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [IW-1:0] sa, sb, xd;
        logic          xw, xl;
        logic [IW-1:0] md;
        logic          mw;
        logic [1:0]    ea, eb;
        logic          es;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{5'd1,  5'd2,  5'd20, 1'b0, 1'b0, 5'd21, 1'b0, 2'b00, 2'b00, 1'b0}, // R1
        '{5'd3,  5'd2,  5'd3,  1'b1, 1'b0, 5'd21, 1'b0, 2'b01, 2'b00, 1'b0}, // R2
        '{5'd1,  5'd4,  5'd4,  1'b1, 1'b0, 5'd21, 1'b0, 2'b00, 2'b01, 1'b0}, // R2 R10
        '{5'd5,  5'd2,  5'd20, 1'b1, 1'b0, 5'd5,  1'b1, 2'b10, 2'b00, 1'b0}, // R3
        '{5'd6,  5'd6,  5'd6,  1'b1, 1'b0, 5'd6,  1'b1, 2'b01, 2'b01, 1'b0}, // R4
        '{5'd0,  5'd0,  5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 2'b00, 2'b00, 1'b0}, // R5
        '{5'd7,  5'd7,  5'd7,  1'b0, 1'b0, 5'd7,  1'b0, 2'b00, 2'b00, 1'b0}, // R6
        '{5'd8,  5'd2,  5'd8,  1'b1, 1'b1, 5'd21, 1'b0, 2'b00, 2'b00, 1'b1}, // R7 R8
        '{5'd9,  5'd2,  5'd9,  1'b1, 1'b1, 5'd9,  1'b1, 2'b10, 2'b00, 1'b1}, // R7
        '{5'd1,  5'd10, 5'd10, 1'b1, 1'b1, 5'd21, 1'b0, 2'b00, 2'b00, 1'b1}, // R8
        '{5'd11, 5'd12, 5'd11, 1'b1, 1'b0, 5'd12, 1'b1, 2'b01, 2'b10, 1'b0}, // R10
        '{5'd1,  5'd2,  5'd13, 1'b1, 1'b1, 5'd21, 1'b0, 2'b00, 2'b00, 1'b0}, // R8
        '{5'd0,  5'd2,  5'd0,  1'b1, 1'b1, 5'd21, 1'b0, 2'b00, 2'b00, 1'b0}, // R5 R8
        '{5'd14, 5'd2,  5'd14, 1'b0, 1'b1, 5'd21, 1'b0, 2'b00, 2'b00, 1'b0}  // R6 R8
    };

    function automatic logic [DW-1:0] exp_val(input logic [1:0] s, input logic [DW-1:0] rf);
        case (s)
            2'b01:   return xr;
            2'b10:   return mwd;
            default: return rf;
        endcase
    endfunction

    task automatic apply(input vec_t v);
        @(negedge clk);
        sa = v.sa; sb = v.sb; xd = v.xd; xw = v.xw; xl = v.xl;
        md = v.md; mw = v.mw;
        rfa = 32'hA000_0000 | 32'(v.sa);
        rfb = 32'hB000_0000 | 32'(v.sb);
        xr  = 32'hC000_0000 | 32'(v.xd);
        mwd = 32'hD000_0000 | 32'(v.md);
        #1;
    endtask

    initial begin : watchdog
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        sa = '0; sb = '0; xd = '0; md = '0; xw = 0; xl = 0; mw = 0;
        rfa = 32'h1111; rfb = 32'h2222; xr = 32'h3333; mwd = 32'h4444;
        repeat (3) @(posedge clk);
        #1;
        // reset state: idle inputs read register file, no stall (R1)
        chk("R1 reset sel_a", 32'(sela), 32'd0);
        chk("R1 reset opnd_a", oa, 32'h1111);
        chk("R8 reset stall", 32'(stl), 32'd0);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            chk($sformatf("vec%0d sel_a", i), 32'(sela), 32'(VEC[i].ea));
            chk($sformatf("vec%0d sel_b", i), 32'(selb), 32'(VEC[i].eb));
            chk($sformatf("vec%0d opnd_a", i), oa, exp_val(VEC[i].ea, rfa));
            chk($sformatf("vec%0d opnd_b", i), ob, exp_val(VEC[i].eb, rfb));
            chk($sformatf("vec%0d R8 stall", i), 32'(stl), 32'(VEC[i].es));
            chk($sformatf("vec%0d R9 stall_dly", i), 32'(stl_d), 32'd0);
            chk($sformatf("vec%0d R7 dly sel_a", i), 32'(sela_d), 32'(VEC[i].ea));
            chk($sformatf("vec%0d R7 dly opnd_a", i), oa_d, exp_val(VEC[i].ea, rfa));
        end

        // R7 R9 delayed slot: load hit on B with older producer keeps old value
        apply('{5'd3, 5'd15, 5'd15, 1'b1, 1'b1, 5'd15, 1'b1, 2'b00, 2'b10, 1'b1});
        chk("R7 dly sel_b", 32'(selb_d), 32'd2);
        chk("R7 dly opnd_b", ob_d, mwd);
        chk("R9 dly no stall", 32'(stl_d), 32'd0);
        chk("R8 stall both-mode", 32'(stl), 32'd1);

        // R4 R10: highest register index, both producers, B different
        apply('{5'd31, 5'd30, 5'd31, 1'b1, 1'b0, 5'd30, 1'b1, 2'b01, 2'b10, 1'b0});
        chk("R4 sel_a r31", 32'(sela), 32'd1);
        chk("R10 sel_b r30", 32'(selb), 32'd2);
        chk("R10 opnd_b r30", ob, mwd);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule